// File: doc/BRIEF.md
# Vsync-Latched Window Shadow Register Bank

This block keeps the per-window settings of a multi-window display controller in two copies. Software writes land in a pending copy. The display pipeline only sees the active copy. Each window holds a buffer start address, an on-screen position and a window enable. A channel enable for each window sits in a shared control register. The active copy of a window is loaded from its pending copy in the cycle a vertical-sync pulse arrives. That is also the moment the next frame's fetch begins, so a frame never mixes old and new settings.

Software can set a window's protect bit while it edits several fields of that window. While the bit is set, a vsync leaves the whole window group untouched. Once software clears the bit, the whole group moves together at the following vsync. A global video-enable bit is shadowed in the same way, but protect bits do not hold it back.

To confirm a page flip, software can read both copies of any window's start address. It can also watch a one-cycle flip-done pulse, which fires when a window's active start address changes at vsync.

Top module: `vs_shadow_bank`

## Requirements
- R1: After reset, every pending field, every active field, every protect bit and every channel enable is 0, and `flip_done` is 0.
- R2: A write with `cfg_we` high updates only the pending field it selects, chosen by `cfg_win` and `cfg_sel`. `cfg_sel` 0 selects the start address (the full `cfg_wdata`). `cfg_sel` 1 selects the position, with X in `cfg_wdata[CW-1:0]` and Y in `cfg_wdata[2*CW-1:CW]`. `cfg_sel` 2 selects the window enable (`cfg_wdata[0]`). Without a vsync, active outputs never change.
- R3: At a vsync edge for a window whose protect bit is 0, the window's pending start address, position, window enable and channel enable all appear on the active outputs together, from the cycle after that edge.
- R4: At a vsync edge for a window whose protect bit is 1, none of that window's active fields change. At the first vsync after the bit returns to 0, all of them are loaded.
- R5: When a pending write and a vsync fall in the same cycle, the active copy takes the value that was pending before the write. The written value is loaded at the next vsync.
- R6: Clearing a window enable or a channel enable leaves the active bit at 1 until the next vsync.
- R7: `vid_we` writes the pending global video enable. `act_vid_en` takes that pending value at every vsync edge, whatever the protect bits hold.
- R8: `flip_done[w]` is high for exactly the one cycle after a vsync edge that changed window w's active start address. It stays low if the address was unchanged or the window was protected.
- R9: `rd_pend_addr` and `rd_act_addr` return the pending and active start address of window `rd_win`, combinationally. They return 0 when `rd_win` names no window. The two are equal once a flip has taken effect.
- R10: A write with `cfg_sel` equal to 3 changes no pending or active field.
- R11: `ctl_we` writes the shared control register. Bits `[NWIN-1:0]` are the pending channel enables. Bits `[2*NWIN-1:NWIN]` are the protect bits. A protect bit acts on the very next vsync edge after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical-sync pulse; loads active copies |
| cfg_we | input | 1 | Window field write strobe |
| cfg_win | input | WIN_W | Window index for the write |
| cfg_sel | input | 2 | Field select: 0 start, 1 position, 2 enable, 3 none |
| cfg_wdata | input | AW | Write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2*NWIN | Channel enables (low half), protect bits (high half) |
| vid_we | input | 1 | Global video-enable write strobe |
| vid_wdata | input | 1 | Pending global video enable |
| rd_win | input | WIN_W | Window index for address readback |
| rd_pend_addr | output | AW | Pending start address of `rd_win` |
| rd_act_addr | output | AW | Active start address of `rd_win` |
| act_start | output | NWIN*AW | Active start addresses, window w at `[w*AW +: AW]` |
| act_pos | output | NWIN*2*CW | Active positions, window w at `[w*2*CW +: 2*CW]` |
| act_win_en | output | NWIN | Active window enables |
| act_chan_en | output | NWIN | Active channel enables |
| act_vid_en | output | 1 | Active global video enable |
| flip_done | output | NWIN | One-cycle pulse per window on an address change at vsync |

## Verification
The bench writes to pending registers in the same cycle as a vsync. A design that forwards the new value would show it on the active outputs one frame early. It also protects a window, edits several of its fields and fires vsyncs in both states. A design that ignored protect, or loaded only some of the fields, would show a partial update.

Disables are checked to hold until vsync, so a design that let them act at once would blank a window mid-frame. The bench also fires repeated vsyncs with no address change. A flip-done that was level-based, or that ignored protect, would pulse where no flip occurred.

// File: rtl/vs_shadow_bank_pkg.sv
package vs_shadow_bank_pkg;
  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_POS    = 2'd1,
    FLD_ENABLE = 2'd2,
    FLD_RSVD   = 2'd3
  } fld_e;
endpackage

// File: rtl/vs_win_regs.sv
module vs_win_regs #(
  parameter int AW = 32,
  parameter int CW = 12,
  localparam int PW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr_start,
  input  logic          wr_pos,
  input  logic          wr_ena,
  input  logic [AW-1:0] wdata,
  input  logic          chan_pend,
  output logic [AW-1:0] pend_start,
  output logic [AW-1:0] act_start,
  output logic [PW-1:0] act_pos,
  output logic          act_ena,
  output logic          act_chan,
  output logic          flip
);
  logic [AW-1:0] pstart_q, pstart_d, astart_q, astart_d;
  logic [PW-1:0] ppos_q, ppos_d, apos_q, apos_d;
  logic          pena_q, pena_d, aena_q, aena_d;
  logic          achan_q, achan_d;
  logic          flip_q, flip_d;

  // next state: active copy takes the pre-write pending value
  always_comb begin
    pstart_d = pstart_q;
    ppos_d   = ppos_q;
    pena_d   = pena_q;
    if (wr_start) pstart_d = wdata;
    if (wr_pos)   ppos_d   = wdata[PW-1:0];
    if (wr_ena)   pena_d   = wdata[0];

    astart_d = astart_q;
    apos_d   = apos_q;
    aena_d   = aena_q;
    achan_d  = achan_q;
    flip_d   = 1'b0;
    if (load) begin
      astart_d = pstart_q;
      apos_d   = ppos_q;
      aena_d   = pena_q;
      achan_d  = chan_pend;
      flip_d   = (pstart_q != astart_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstart_q <= '0;
      ppos_q   <= '0;
      pena_q   <= 1'b0;
      astart_q <= '0;
      apos_q   <= '0;
      aena_q   <= 1'b0;
      achan_q  <= 1'b0;
      flip_q   <= 1'b0;
    end else begin
      pstart_q <= pstart_d;
      ppos_q   <= ppos_d;
      pena_q   <= pena_d;
      astart_q <= astart_d;
      apos_q   <= apos_d;
      aena_q   <= aena_d;
      achan_q  <= achan_d;
      flip_q   <= flip_d;
    end
  end

  assign pend_start = pstart_q;
  assign act_start  = astart_q;
  assign act_pos    = apos_q;
  assign act_ena    = aena_q;
  assign act_chan   = achan_q;
  assign flip       = flip_q;
endmodule

// File: rtl/vs_ctl_regs.sv
module vs_ctl_regs #(
  parameter int NWIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              ctl_we,
  input  logic [2*NWIN-1:0] ctl_wdata,
  input  logic              vid_we,
  input  logic              vid_wdata,
  output logic [NWIN-1:0]   chan_pend,
  output logic [NWIN-1:0]   prot,
  output logic              vid_pend,
  output logic              vid_act
);
  logic [NWIN-1:0] chan_q, chan_d, prot_q, prot_d;
  logic            vp_q, vp_d, va_q, va_d;

  always_comb begin
    chan_d = chan_q;
    prot_d = prot_q;
    vp_d   = vp_q;
    va_d   = va_q;
    if (ctl_we) begin
      chan_d = ctl_wdata[NWIN-1:0];
      prot_d = ctl_wdata[2*NWIN-1:NWIN];
    end
    if (vid_we) vp_d = vid_wdata;
    if (vsync)  va_d = vp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      prot_q <= '0;
      vp_q   <= 1'b0;
      va_q   <= 1'b0;
    end else begin
      chan_q <= chan_d;
      prot_q <= prot_d;
      vp_q   <= vp_d;
      va_q   <= va_d;
    end
  end

  assign chan_pend = chan_q;
  assign prot      = prot_q;
  assign vid_pend  = vp_q;
  assign vid_act   = va_q;
endmodule

// File: rtl/vs_shadow_bank.sv
module vs_shadow_bank
  import vs_shadow_bank_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int AW   = 32,
  parameter int CW   = 12,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int PW    = 2 * CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync,
  input  logic                 cfg_we,
  input  logic [WIN_W-1:0]     cfg_win,
  input  logic [1:0]           cfg_sel,
  input  logic [AW-1:0]        cfg_wdata,
  input  logic                 ctl_we,
  input  logic [2*NWIN-1:0]    ctl_wdata,
  input  logic                 vid_we,
  input  logic                 vid_wdata,
  input  logic [WIN_W-1:0]     rd_win,
  output logic [AW-1:0]        rd_pend_addr,
  output logic [AW-1:0]        rd_act_addr,
  output logic [NWIN*AW-1:0]   act_start,
  output logic [NWIN*PW-1:0]   act_pos,
  output logic [NWIN-1:0]      act_win_en,
  output logic [NWIN-1:0]      act_chan_en,
  output logic                 act_vid_en,
  output logic [NWIN-1:0]      flip_done
);
  fld_e              fld;
  logic [NWIN-1:0]   chan_pend;
  logic [NWIN-1:0]   prot;
  logic              vid_pend;
  logic [NWIN*AW-1:0] pend_start;

  assign fld = fld_e'(cfg_sel);

  vs_ctl_regs #(.NWIN(NWIN)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync     (vsync),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .vid_we    (vid_we),
    .vid_wdata (vid_wdata),
    .chan_pend (chan_pend),
    .prot      (prot),
    .vid_pend  (vid_pend),
    .vid_act   (act_vid_en)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic hit;
    assign hit = cfg_we && (cfg_win == WIN_W'(w));

    vs_win_regs #(.AW(AW), .CW(CW)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (vsync && !prot[w]),
      .wr_start   (hit && (fld == FLD_START)),
      .wr_pos     (hit && (fld == FLD_POS)),
      .wr_ena     (hit && (fld == FLD_ENABLE)),
      .wdata      (cfg_wdata),
      .chan_pend  (chan_pend[w]),
      .pend_start (pend_start[w*AW +: AW]),
      .act_start  (act_start[w*AW +: AW]),
      .act_pos    (act_pos[w*PW +: PW]),
      .act_ena    (act_win_en[w]),
      .act_chan   (act_chan_en[w]),
      .flip       (flip_done[w])
    );
  end

  always_comb begin
    rd_pend_addr = '0;
    rd_act_addr  = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (rd_win == WIN_W'(w)) begin
        rd_pend_addr = pend_start[w*AW +: AW];
        rd_act_addr  = act_start[w*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/vs_shadow_bank_chk.sv
module vs_shadow_bank_chk #(
  parameter int NWIN = 5,
  parameter int AW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vsync,
  input logic [NWIN-1:0]    prot,
  input logic [NWIN*AW-1:0] pend_start,
  input logic [NWIN*AW-1:0] act_start,
  input logic [NWIN-1:0]    act_win_en,
  input logic [NWIN-1:0]    flip_done,
  input logic               vid_pend,
  input logic               act_vid_en
);
  for (genvar w = 0; w < NWIN; w++) begin : g_chk
    a_r3_load_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !prot[w]) |=> (act_start[w*AW +: AW] == $past(pend_start[w*AW +: AW])));

    a_r4_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && prot[w]) |=> ($stable(act_start[w*AW +: AW]) && $stable(act_win_en[w])));

    a_r2_no_vsync_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> ($stable(act_start[w*AW +: AW]) && $stable(act_win_en[w])));

    a_r8_flip_means_change: assert property (@(posedge clk) disable iff (!rst_n)
      flip_done[w] |-> (act_start[w*AW +: AW] != $past(act_start[w*AW +: AW])));
  end

  a_r7_vid_load: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (act_vid_en == $past(vid_pend)));

  a_r7_vid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_vid_en));
endmodule

bind vs_shadow_bank vs_shadow_bank_chk #(.NWIN(NWIN), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync      (vsync),
  .prot       (prot),
  .pend_start (pend_start),
  .act_start  (act_start),
  .act_win_en (act_win_en),
  .flip_done  (flip_done),
  .vid_pend   (vid_pend),
  .act_vid_en (act_vid_en)
);

// File: tb/vs_shadow_bank_bench.sv
`timescale 1ns/1ps
module vs_shadow_bank_bench;
  localparam int NWIN  = 5;
  localparam int AW    = 32;
  localparam int CW    = 12;
  localparam int PW    = 2 * CW;
  localparam int WIN_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic vsync, cfg_we, ctl_we, vid_we, vid_wdata;
  logic [WIN_W-1:0] cfg_win, rd_win;
  logic [1:0] cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic [2*NWIN-1:0] ctl_wdata;
  logic [AW-1:0] rd_pend_addr, rd_act_addr;
  logic [NWIN*AW-1:0] act_start;
  logic [NWIN*PW-1:0] act_pos;
  logic [NWIN-1:0] act_win_en, act_chan_en, flip_done;
  logic act_vid_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vs_shadow_bank u_vs_shadow_bank (
    .clk(clk), .rst_n(rst_n), .vsync(vsync),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .vid_we(vid_we), .vid_wdata(vid_wdata),
    .rd_win(rd_win), .rd_pend_addr(rd_pend_addr), .rd_act_addr(rd_act_addr),
    .act_start(act_start), .act_pos(act_pos), .act_win_en(act_win_en),
    .act_chan_en(act_chan_en), .act_vid_en(act_vid_en), .flip_done(flip_done)
  );

  // behavioural reference model
  logic [AW-1:0] m_ps [NWIN];
  logic [AW-1:0] m_as [NWIN];
  logic [PW-1:0] m_pp [NWIN];
  logic [PW-1:0] m_ap [NWIN];
  bit m_pw [NWIN];
  bit m_aw [NWIN];
  bit m_ac [NWIN];
  bit m_fl [NWIN];
  bit m_chan [NWIN];
  bit m_prot [NWIN];
  bit m_vid, m_avid;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        m_ps[i] = '0; m_as[i] = '0; m_pp[i] = '0; m_ap[i] = '0;
        m_pw[i] = 0; m_aw[i] = 0; m_ac[i] = 0; m_fl[i] = 0;
        m_chan[i] = 0; m_prot[i] = 0;
      end
      m_vid = 0; m_avid = 0;
    end else begin
      for (int i = 0; i < NWIN; i++) begin
        m_fl[i] = 0;
        if (vsync && !m_prot[i]) begin
          m_fl[i] = (m_as[i] != m_ps[i]);
          m_as[i] = m_ps[i]; m_ap[i] = m_pp[i];
          m_aw[i] = m_pw[i]; m_ac[i] = m_chan[i];
        end
      end
      if (vsync) m_avid = m_vid;
      if (cfg_we && int'(cfg_win) < NWIN) begin
        case (cfg_sel)
          2'd0: m_ps[cfg_win] = cfg_wdata;
          2'd1: m_pp[cfg_win] = cfg_wdata[PW-1:0];
          2'd2: m_pw[cfg_win] = cfg_wdata[0];
          default: ;
        endcase
      end
      if (ctl_we)
        for (int i = 0; i < NWIN; i++) begin
          m_chan[i] = ctl_wdata[i];
          m_prot[i] = ctl_wdata[NWIN+i];
        end
      if (vid_we) m_vid = vid_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic [NWIN*AW-1:0] e_s;
      logic [NWIN*PW-1:0] e_p;
      logic [NWIN-1:0] e_w, e_c, e_f;
      for (int i = 0; i < NWIN; i++) begin
        e_s[i*AW +: AW] = m_as[i];
        e_p[i*PW +: PW] = m_ap[i];
        e_w[i] = m_aw[i]; e_c[i] = m_ac[i]; e_f[i] = m_fl[i];
      end
      total++;
      if (act_start !== e_s || act_pos !== e_p || act_win_en !== e_w ||
          act_chan_en !== e_c || flip_done !== e_f || act_vid_en !== m_avid) begin
        bad++;
        $display("FAIL R3 model compare t=%0t actual start=%h en=%b chan=%b flip=%b vid=%b expected start=%h en=%b chan=%b flip=%b vid=%b",
                 $time, act_start, act_win_en, act_chan_en, flip_done, act_vid_en,
                 e_s, e_w, e_c, e_f, m_avid);
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(int w, int sel, logic [AW-1:0] d);
    cfg_we = 1; cfg_win = WIN_W'(w); cfg_sel = 2'(sel); cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic ctl(logic [2*NWIN-1:0] d);
    ctl_we = 1; ctl_wdata = d;
    step();
    ctl_we = 0;
  endtask

  task automatic vs();
    vsync = 1;
    step();
    vsync = 0;
  endtask

  task automatic rd(int w, output logic [AW-1:0] p, output logic [AW-1:0] a);
    rd_win = WIN_W'(w);
    #1;
    p = rd_pend_addr; a = rd_act_addr;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] p, a;
    rst_n = 0; vsync = 0; cfg_we = 0; cfg_win = '0; cfg_sel = '0; cfg_wdata = '0;
    ctl_we = 0; ctl_wdata = '0; vid_we = 0; vid_wdata = 0; rd_win = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 act_start", 64'(act_start), 64'h0);
    chk("R1 flip_done", 64'(flip_done), 64'h0);
    chk("R1 enables", 64'({act_win_en, act_chan_en, act_vid_en}), 64'h0);

    // R2 pending-only write
    cfg(1, 0, 32'h1000_0000);
    rd(1, p, a);
    chk("R2 pending start", 64'(p), 64'h1000_0000);
    chk("R2 active untouched", 64'(a), 64'h0);
    cfg(1, 1, 32'h0001_400A);
    cfg(1, 2, 32'h1);
    ctl(10'b00000_00010);
    chk("R6 enable waits for vsync", 64'(act_win_en[1]), 64'h0);

    // R3 whole group loads at vsync, R8 flip pulse
    vs();
    chk("R3 start", 64'(act_start[1*AW +: AW]), 64'h1000_0000);
    chk("R3 position", 64'(act_pos[1*PW +: PW]), 64'h01_400A);
    chk("R3 win enable", 64'(act_win_en[1]), 64'h1);
    chk("R3 chan enable", 64'(act_chan_en[1]), 64'h1);
    chk("R8 flip pulse", 64'(flip_done), 64'h02);
    rd(1, p, a);
    chk("R9 readback equal after flip", 64'(p == a), 64'h1);
    step();
    chk("R8 pulse one cycle", 64'(flip_done), 64'h0);
    vs();
    chk("R8 no pulse without change", 64'(flip_done), 64'h0);

    // R4 / R11 protect
    ctl(10'b00010_00010);
    cfg(1, 0, 32'h2000_0000);
    cfg(1, 1, 32'h0000_5006);
    vs();
    chk("R4 start held", 64'(act_start[1*AW +: AW]), 64'h1000_0000);
    chk("R4 position held", 64'(act_pos[1*PW +: PW]), 64'h01_400A);
    chk("R8 no pulse when protected", 64'(flip_done), 64'h0);
    ctl(10'b00000_00010);
    chk("R11 unprotect alone loads nothing", 64'(act_start[1*AW +: AW]), 64'h1000_0000);
    vs();
    chk("R4 start after unprotect", 64'(act_start[1*AW +: AW]), 64'h2000_0000);
    chk("R4 position after unprotect", 64'(act_pos[1*PW +: PW]), 64'h00_5006);

    // R6 disables wait for vsync
    cfg(1, 2, 32'h0);
    ctl(10'b00000_00000);
    chk("R6 win enable held", 64'(act_win_en[1]), 64'h1);
    chk("R6 chan enable held", 64'(act_chan_en[1]), 64'h1);
    vs();
    chk("R6 win disabled", 64'(act_win_en[1]), 64'h0);
    chk("R6 chan disabled", 64'(act_chan_en[1]), 64'h0);

    // R5 write colliding with vsync
    cfg_we = 1; cfg_win = 3'd2; cfg_sel = 2'd0; cfg_wdata = 32'h3000_0040; vsync = 1;
    step();
    cfg_we = 0; vsync = 0;
    chk("R5 old value loaded", 64'(act_start[2*AW +: AW]), 64'h0);
    vs();
    chk("R5 new value next vsync", 64'(act_start[2*AW +: AW]), 64'h3000_0040);

    // R7 global enable ignores protect
    vid_we = 1; vid_wdata = 1; step(); vid_we = 0;
    chk("R7 waits for vsync", 64'(act_vid_en), 64'h0);
    ctl(10'b11111_00000);
    vs();
    chk("R7 loads under protect", 64'(act_vid_en), 64'h1);
    ctl(10'b00000_00000);

    // R10 reserved select
    cfg(3, 3, 32'hDEAD_BEEF);
    vs();
    rd(3, p, a);
    chk("R10 pending unchanged", 64'(p), 64'h0);
    chk("R10 active unchanged", 64'({act_start[3*AW +: AW], act_pos[3*PW +: PW], act_win_en[3]}), 64'h0);

    // R9 out of range index
    rd(7, p, a);
    chk("R9 no window pending", 64'(p), 64'h0);
    chk("R9 no window active", 64'(a), 64'h0);

    // R3 all windows in one vsync
    for (int w = 0; w < NWIN; w++) cfg(w, 0, 32'h4000_0000 + 32'(w) * 32'h100);
    vs();
    for (int w = 0; w < NWIN; w++)
      chk("R3 all windows", 64'(act_start[w*AW +: AW]), 64'(32'h4000_0000 + 32'(w) * 32'h100));
    chk("R8 all flipped", 64'(flip_done), 64'h1F);
    step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule